// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Controller

This peripheral provides two 16-bit down-counters and a small interrupt controller behind a byte-wide register bus. A shared tick-enable input advances both counters. The expected tick rate is the core clock divided by six: about 783 kHz from a 4.7 MHz reference. The first timer runs either one-shot or free-running with automatic reload, as a control register selects. The second timer is always one-shot. Software arms it by writing its high byte, and that write copies the assembled 16-bit latch into the counter.

A third interrupt source is a shift-register event request. If every port B direction bit is set, the request raises its flag on the next clock edge. Otherwise the flag is raised only after a fixed number of ticks, set by a parameter that defaults to about 300 microseconds at the nominal tick rate. A new request during that wait starts the count again. The single interrupt output is the OR of the enabled pending flags.

Register addresses are 0 (timer 1 counter low), 1 (timer 1 counter high), 2 (timer 2 counter low), 3 (timer 2 counter high), 4 (mode), 5 (port B direction), 6 (flags) and 7 (enables). Flag and enable bit 0 is the shift-register event, bit 1 is timer 2 and bit 2 is timer 1. Read data is combinational on `addr`. Read side effects happen on the clock edge where `rd_en` is high.

Top module: `twin_timer_irq`

## Requirements
- R1: `irq` is high exactly when (flags AND enables) has bit 0, 1 or 2 set. Reading address 6 returns `irq` in bit 7 and the flags in bits 2:0.
- R2: A write to address 2 replaces only the low byte of the timer 2 latch. The timer 2 counter keeps its value.
- R3: A write to address 3 sets the latch high byte, clears flag bit 1 and loads the counter with the full 16-bit latch. Reads of address 2 and 3 return the counter low and high bytes.
- R4: A read (`rd_en`) of address 2 returns the counter's low byte and clears flag bit 1.
- R5: Each tick decrements a loaded counter. The tick that finds the counter at zero sets the timer's flag, so a load of N fires after N+1 ticks. Timer 2 then continues from 0xFFFF and sets no further flag until it is reloaded, whatever the mode register holds.
- R6: With mode bit 0 set, timer 1 reloads from its latch on the firing tick and fires every N+1 ticks. With mode bit 0 clear, it behaves one-shot like timer 2.
- R7: After reset, both latches and both counters are 0xFFFF, the port B direction register is 0xFF, and the flags, enables and mode are 0.
- R8: A shift-register request while the direction register is 0xFF sets flag bit 0 on the same clock edge.
- R9: With any direction bit clear, a request sets flag bit 0 on the SR_DELAY_TICKS-th tick after it. A new request during the wait restarts the count.
- R10: Writing address 6 clears each flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R11: Timer 1 at addresses 0 and 1 follows the same latch, load, flag-clear and read-clear rules as timer 2, using flag bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; applies read side effects |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tick_en | input | 1 | Counter advance enable |
| sr_req | input | 1 | Shift-register interrupt request pulse |
| irq | output | 1 | Interrupt output |

## Verification
Randomized trials load either timer with small random values under random enable masks and random mode bits. Counting the ticks to the firing edge separates an off-by-one in the zero-crossing test from a correct N+1 period. The state after firing tells a continuous reload apart from a one-shot wrap. Directed cases cover the following:
- a low-byte write followed by a high-byte write, which shows that only the high write loads the counter;
- a reset-latch load, which exposes the 0xFFFF reset latch;
- read-to-clear behaviour;
- selective flag clearing;
- the immediate, delayed and restarted shift-register paths, each checked one tick short of and exactly at its expected edge.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int NUM_TMR = 2;
    localparam int NFLAGS = 3;

    localparam int FLAG_SR = 0;
    localparam int FLAG_T2 = 1;
    localparam int FLAG_T1 = 2;

    localparam int MODE_T1_CONT = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_T1_LO = 3'd0,
        REG_T1_HI = 3'd1,
        REG_T2_LO = 3'd2,
        REG_T2_HI = 3'd3,
        REG_MODE  = 3'd4,
        REG_DIRB  = 3'd5,
        REG_FLAGS = 3'd6,
        REG_ENAB  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
    } tmr_acc_t;

    function automatic logic [ADDR_W-1:0] tmr_lo_addr(input int idx);
        return ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] tmr_hi_addr(input int idx);
        return ADDR_W'(2 * idx + 1);
    endfunction

    function automatic int tmr_flag(input int idx);
        return (idx == 0) ? FLAG_T1 : FLAG_T2;
    endfunction

endpackage

// File: rtl/tt_countdown.sv
module tt_countdown #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    output logic [W-1:0] count,
    output logic         expire
);
    logic armed;

    assign expire = tick && !load && armed && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
            armed <= 1'b0;
        end else if (load) begin
            count <= load_val;
            armed <= 1'b1;
        end else if (tick) begin
            if (count == '0) begin
                count <= reload ? load_val : '1;
                if (!reload) begin
                    armed <= 1'b0;
                end
            end else begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tt_timer.sv
module tt_timer
    import tt_pkg::*;
#(
    parameter int W          = 16,
    parameter bit CAN_RELOAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tmr_acc_t          acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cont_mode,
    output logic [W-1:0]      count,
    output logic              expire
);
    localparam int HI_LSB = DATA_W;

    logic [W-1:0] latch_q;
    logic [W-1:0] latch_nx;

    always_comb begin
        latch_nx = latch_q;
        if (acc.wr_lo) begin
            latch_nx[HI_LSB-1:0] = wdata;
        end
        if (acc.wr_hi) begin
            latch_nx[W-1:HI_LSB] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
        end else begin
            latch_q <= latch_nx;
        end
    end

    tt_countdown #(.W(W)) u_cd (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (acc.wr_hi),
        .load_val (latch_nx),
        .reload   (CAN_RELOAD && cont_mode),
        .count    (count),
        .expire   (expire)
    );
endmodule

// File: rtl/tt_sr_delay.sv
module tt_sr_delay #(
    parameter int DELAY_TICKS = 235
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    input  logic bypass,
    output logic fire
);
    localparam int CW = $clog2(DELAY_TICKS + 1);

    logic          pending;
    logic [CW-1:0] cnt;

    assign fire = (req && bypass) ||
                  (!req && pending && tick && (cnt == CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (req) begin
            pending <= !bypass;
            cnt     <= CW'(DELAY_TICKS);
        end else if (pending && tick) begin
            if (cnt == CW'(1)) begin
                pending <= 1'b0;
            end
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/twin_timer_irq.sv
module twin_timer_irq
    import tt_pkg::*;
#(
    parameter int SR_DELAY_TICKS = 235
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_en,
    input  logic              sr_req,
    output logic              irq
);
    logic [NFLAGS-1:0] ifr;
    logic [NFLAGS-1:0] ier;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] dirb;
    logic [NFLAGS-1:0] set_v;
    logic [NFLAGS-1:0] clr_v;
    logic              sr_fire;

    tmr_acc_t          acc        [NUM_TMR];
    logic [CNT_W-1:0]  tmr_count  [NUM_TMR];
    logic              tmr_expire [NUM_TMR];

    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) begin
            acc[i].wr_lo = wr_en && (addr == tmr_lo_addr(i));
            acc[i].wr_hi = wr_en && (addr == tmr_hi_addr(i));
        end
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tt_timer #(
            .W          (CNT_W),
            .CAN_RELOAD (g == 0)
        ) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_en),
            .acc       (acc[g]),
            .wdata     (wdata),
            .cont_mode (mode_q[MODE_T1_CONT]),
            .count     (tmr_count[g]),
            .expire    (tmr_expire[g])
        );
    end

    tt_sr_delay #(.DELAY_TICKS(SR_DELAY_TICKS)) u_srd (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .req    (sr_req),
        .bypass (dirb == '1),
        .fire   (sr_fire)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[FLAG_SR] = sr_fire;
        for (int i = 0; i < NUM_TMR; i++) begin
            set_v[tmr_flag(i)] = tmr_expire[i];
            if (acc[i].wr_hi || (rd_en && addr == tmr_lo_addr(i))) begin
                clr_v[tmr_flag(i)] = 1'b1;
            end
        end
        if (wr_en && addr == REG_FLAGS) begin
            clr_v = clr_v | wdata[NFLAGS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ifr    <= '0;
            ier    <= '0;
            mode_q <= '0;
            dirb   <= '1;
        end else begin
            ifr <= (ifr & ~clr_v) | set_v;
            if (wr_en && addr == REG_ENAB) begin
                ier <= wdata[NFLAGS-1:0];
            end
            if (wr_en && addr == REG_MODE) begin
                mode_q <= wdata;
            end
            if (wr_en && addr == REG_DIRB) begin
                dirb <= wdata;
            end
        end
    end

    assign irq = |(ifr & ier);

    always_comb begin
        case (reg_sel_e'(addr))
            REG_T1_LO: rdata = tmr_count[0][7:0];
            REG_T1_HI: rdata = tmr_count[0][CNT_W-1:8];
            REG_T2_LO: rdata = tmr_count[1][7:0];
            REG_T2_HI: rdata = tmr_count[1][CNT_W-1:8];
            REG_MODE:  rdata = mode_q;
            REG_DIRB:  rdata = dirb;
            REG_FLAGS: rdata = {irq, {(DATA_W-NFLAGS-1){1'b0}}, ifr};
            default:   rdata = {{(DATA_W-NFLAGS){1'b0}}, ier};
        endcase
    end
endmodule

// File: rtl/tt_checker.sv
module tt_checker
    import tt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              tick_en,
    input logic              sr_req,
    input logic [DATA_W-1:0] dirb,
    input logic [NFLAGS-1:0] ifr,
    input logic [CNT_W-1:0]  t2_count,
    input logic              t2_expire,
    input logic              t1_expire
);
    a_r2_low_write_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_T2_LO && !tick_en) |=> $stable(t2_count));

    a_r3_high_write_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_T2_HI) |=> (t2_count[CNT_W-1:8] == $past(wdata)));

    a_r3_high_write_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_T2_HI) |=> !ifr[FLAG_T2]);

    a_r5_t2_no_reload: assert property (@(posedge clk) disable iff (rst)
        t2_expire |=> (t2_count == '1));

    a_r8_sr_immediate: assert property (@(posedge clk) disable iff (rst)
        (sr_req && dirb == 8'hFF) |=> ifr[FLAG_SR]);

    a_r10_flag_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_FLAGS && wdata[FLAG_T1] && !t1_expire) |=> !ifr[FLAG_T1]);
endmodule

bind twin_timer_irq tt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .tick_en   (tick_en),
    .sr_req    (sr_req),
    .dirb      (dirb),
    .ifr       (ifr),
    .t2_count  (tmr_count[1]),
    .t2_expire (tmr_expire[1]),
    .t1_expire (tmr_expire[0])
);

// File: tb/twin_timer_irq_tb.sv
module twin_timer_irq_tb_top;
    localparam int DLY = 12;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] rdata;
    logic       tick_en;
    logic       sr_req;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    twin_timer_irq #(.SR_DELAY_TICKS(DLY)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .tick_en (tick_en),
        .sr_req  (sr_req),
        .irq     (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(input int g, output logic [15:0] v);
        logic [7:0] lo, hi;
        peek(3'(2 * g), lo);
        peek(3'(2 * g + 1), hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk);
        sr_req = 1'b1;
        @(negedge clk);
        sr_req = 1'b0;
    endtask

    function automatic int flag_bit(input int g);
        return (g == 0) ? 2 : 1;
    endfunction

    function automatic logic [15:0] after_fire(input int g, input bit cont, input logic [15:0] n);
        return (g == 0 && cont) ? n : 16'hFFFF;
    endfunction

    task automatic flag_is(input string tag, input int b, input logic exp);
        logic [7:0] v;
        peek(3'd6, v);
        check(tag, 16'(v[b]), 16'(exp));
    endtask

    task automatic run_timer(input int g, input bit cont, input logic [15:0] n, input logic [2:0] en);
        logic [15:0] c;
        logic [7:0]  v;
        int          fb;
        fb = flag_bit(g);
        wr(3'd7, {5'd0, en});
        wr(3'd4, {7'd0, cont});
        wr(3'd6, 8'h07);
        wr(3'(2 * g), n[7:0]);
        wr(3'(2 * g + 1), n[15:8]);
        rd16(g, c);
        check(g == 0 ? "R11 load" : "R3 load", c, n);
        ticks(int'(n));
        rd16(g, c);
        check("R5 count at zero", c, 16'h0000);
        flag_is("R5 no early flag", fb, 1'b0);
        ticks(1);
        flag_is("R5 flag on crossing", fb, 1'b1);
        #1 check("R1 irq", 16'(irq), 16'(en[fb]));
        peek(3'd6, v);
        check("R1 bit7", 16'(v[7]), 16'(en[fb]));
        rd16(g, c);
        check(g == 0 ? "R6 after fire" : "R5 after fire", c, after_fire(g, cont, n));
        wr(3'd6, 8'(1 << fb));
        flag_is("R10 clear", fb, 1'b0);
        ticks(int'(n) + 1);
        flag_is(g == 0 ? "R6 second period" : "R5 one-shot", fb, (g == 0) && cont);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        logic [7:0]  v;
        int          seed;
        seed = $urandom(32'h5EED);
        rst = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        tick_en = 1'b0; sr_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd16(0, c); check("R7 t1 counter", c, 16'hFFFF);
        rd16(1, c); check("R7 t2 counter", c, 16'hFFFF);
        peek(3'd5, v); check("R7 dirb", 16'(v), 16'h00FF);
        peek(3'd6, v); check("R7 flags", 16'(v), 16'h0000);
        peek(3'd7, v); check("R7 enables", 16'(v), 16'h0000);
        peek(3'd4, v); check("R7 mode", 16'(v), 16'h0000);
        #1 check("R7 irq", 16'(irq), 16'h0);
        wr(3'd3, 8'h00);
        rd16(1, c); check("R7 t2 latch low", c, 16'h00FF);

        wr(3'd2, 8'h50); wr(3'd3, 8'h00);
        wr(3'd2, 8'h11);
        rd16(1, c); check("R2 low write no load", c, 16'h0050);
        wr(3'd3, 8'h02);
        rd16(1, c); check("R3 full latch load", c, 16'h0211);

        wr(3'd2, 8'h34); wr(3'd3, 8'h02);
        ticks(2);
        rd(3'd2, v); check("R4 read low", 16'(v), 16'h0032);
        wr(3'd2, 8'h01); wr(3'd3, 8'h00);
        ticks(2);
        flag_is("R4 flag set", 1, 1'b1);
        rd(3'd2, v);
        flag_is("R4 read clears", 1, 1'b0);

        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        ticks(1);
        wr(3'd6, 8'h00);
        flag_is("R10 zero write keeps", 1, 1'b1);
        wr(3'd6, 8'h04);
        flag_is("R10 other bit keeps", 1, 1'b1);
        wr(3'd3, 8'h00);
        flag_is("R3 high write clears", 1, 1'b0);

        wr(3'd0, 8'h03); wr(3'd1, 8'h00);
        ticks(4);
        flag_is("R11 t1 flag", 2, 1'b1);
        rd(3'd0, v);
        flag_is("R11 read clears", 2, 1'b0);

        wr(3'd6, 8'h07);
        pulse_req();
        flag_is("R8 immediate", 0, 1'b1);
        wr(3'd6, 8'h01);
        wr(3'd5, 8'h0F);
        pulse_req();
        ticks(DLY - 1);
        flag_is("R9 not yet", 0, 1'b0);
        ticks(1);
        flag_is("R9 delayed", 0, 1'b1);
        wr(3'd6, 8'h01);
        pulse_req();
        ticks(5);
        pulse_req();
        ticks(DLY - 1);
        flag_is("R9 restart not yet", 0, 1'b0);
        ticks(1);
        flag_is("R9 restart fires", 0, 1'b1);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'h07);

        run_timer(1, 1'b1, 16'd0, 3'b010);
        run_timer(0, 1'b1, 16'd5, 3'b100);
        run_timer(0, 1'b0, 16'd4, 3'b011);
        for (int t = 0; t < 14; t++) begin
            int g;
            g = int'($urandom % 2);
            run_timer(g, 1'($urandom % 2), 16'($urandom % 24), 3'($urandom % 8));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule